// File: doc/BRIEF.md
# Predicate Mask Instruction Nullifier

This block sits in the execute stage of a five-stage in-order pipeline and carries out a predicate-mask instruction. That instruction holds two 8-bit masks in its immediate field. When it reaches execute, the block picks one of the two according to whether a tested register is zero, and keeps the choice in a mask register. Each of the following instructions then uses up one mask bit, lowest bit first. A zero bit turns that instruction into a no-op while it is still in execute, which is before any architectural state is written. A run of short forward branches that all test the same register can therefore be replaced by a single instruction, with no stall cycles.

Each instruction that leaves execute shifts the mask right and puts a one in at the top. After eight instructions the mask is spent and nothing more is nulled. A stall, or an empty execute slot, does not use up a bit. A non-arithmetic instruction cancels whatever is left of the mask. A second predicate-mask instruction that is not itself nulled replaces the remaining mask with its own. Reset and pipeline flush both leave the mask all ones.

Top module: `pmask_nullifier`

## Requirements
- R1: After a synchronous reset the mask is all ones, so the next valid instruction has `ex_keep_valid`=1 and `ex_nullify`=0.
- R2: A predicate-mask instruction (`ex_class`=1) that advances without being nulled loads `imm_mask_nz` when `reg_is_zero`=0 and loads `imm_mask_z` when `reg_is_zero`=1. It is not nulled by the mask it loads.
- R3: For a valid instruction in execute, `ex_nullify` equals the inverse of mask bit 0 and `ex_keep_valid` equals mask bit 0. The two outputs are never high together. Bit 0 belongs to the first instruction after the load, so mask 0xAA nulls the 1st, 3rd, 5th and 7th following instructions.
- R4: Each advancing arithmetic instruction (`ex_class`=0) shifts the mask right by one and fills bit 7 with a one. After eight such instructions no further instruction is nulled.
- R5: While `stall`=1 the mask does not change, so the stalled instruction keeps its outputs and uses up exactly one bit.
- R6: When `ex_valid`=0 both outputs are 0 and no mask bit is used up.
- R7: An advancing non-arithmetic instruction (`ex_class`=2 or 3) is nulled or kept according to its own bit, and then sets the rest of the mask to all ones.
- R8: A second predicate-mask instruction that is not nulled overwrites the remaining mask with its newly selected mask.
- R9: A predicate-mask instruction nulled by the current mask does not load its masks. It cancels the remaining mask like any other non-arithmetic instruction.
- R10: `flush`=1 sets the mask to all ones at the next edge. This takes priority over loading, shifting and stalling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid | input | 1 | An instruction occupies execute |
| ex_class | input | 2 | Decoded class: 0 arithmetic/logical/compare, 1 predicate-mask, 2 or 3 other |
| imm_mask_nz | input | 8 | Mask used when the tested register is nonzero |
| imm_mask_z | input | 8 | Mask used when the tested register is zero |
| reg_is_zero | input | 1 | Tested register equals zero |
| stall | input | 1 | Execute is held this cycle |
| flush | input | 1 | Pipeline flush |
| ex_nullify | output | 1 | Replace the execute instruction with a no-op |
| ex_keep_valid | output | 1 | The execute instruction proceeds as valid |

## Verification
The main stimulus uses three masks. Alternating 0xAA shows whether the bits are taken LSB-first, with the 7th instruction nulled and the 8th kept. Sparse 0x0F and 0x02 masks separate a fill of ones from a fill of zeros and from a shift that was skipped. An all-zero mask that runs for eight instructions and stops on the ninth shows where the window ends. The same stream also carries stalls, bubbles, a non-arithmetic instruction, a nulled and an un-nulled second mask instruction, and masks chosen under both register-zero values. These show that bits are used up only by advancing instructions, and whether the mask is cancelled, reloaded or held.

// File: rtl/pmask_pkg.sv
package pmask_pkg;
  typedef enum logic [1:0] {
    CLS_ARITH = 2'd0,
    CLS_PMASK = 2'd1,
    CLS_OTHER = 2'd2,
    CLS_SPARE = 2'd3
  } ex_class_e;
endpackage

// File: rtl/pmask_select.sv
module pmask_select #(
  parameter int MASK_W = 8
) (
  input  logic              reg_is_zero,
  input  logic [MASK_W-1:0] mask_nz,
  input  logic [MASK_W-1:0] mask_z,
  output logic [MASK_W-1:0] chosen
);
  always_comb chosen = reg_is_zero ? mask_z : mask_nz;
endmodule

// File: rtl/pmask_shiftreg.sv
module pmask_shiftreg #(
  parameter int MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              advance,
  input  logic              load,
  input  logic              cancel,
  input  logic [MASK_W-1:0] load_val,
  output logic [MASK_W-1:0] mask_q
);
  localparam logic [MASK_W-1:0] ALL_ONES = '1;

  logic [MASK_W-1:0] shifted;

  // Shift right by one place; a one enters at the top bit.
  generate
    for (genvar i = 0; i < MASK_W; i++) begin : g_shift
      if (i == MASK_W - 1) begin : g_top
        assign shifted[i] = 1'b1;
      end else begin : g_mid
        assign shifted[i] = mask_q[i+1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || flush)   mask_q <= ALL_ONES;
    else if (load)      mask_q <= load_val;
    else if (cancel)    mask_q <= ALL_ONES;
    else if (advance)   mask_q <= shifted;
  end
endmodule

// File: rtl/pmask_gate.sv
module pmask_gate (
  input  logic ex_valid,
  input  logic mask_lsb,
  output logic ex_nullify,
  output logic ex_keep_valid
);
  always_comb begin
    ex_nullify    = ex_valid & ~mask_lsb;
    ex_keep_valid = ex_valid &  mask_lsb;
  end
endmodule

// File: rtl/pmask_nullifier.sv
module pmask_nullifier
  import pmask_pkg::*;
#(
  parameter int MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ex_valid,
  input  logic [1:0]        ex_class,
  input  logic [MASK_W-1:0] imm_mask_nz,
  input  logic [MASK_W-1:0] imm_mask_z,
  input  logic              reg_is_zero,
  input  logic              stall,
  input  logic              flush,
  output logic              ex_nullify,
  output logic              ex_keep_valid
);
  logic [MASK_W-1:0] state_q;
  logic [MASK_W-1:0] sel_mask;
  logic              advance, is_pm, is_arith, do_load, do_cancel;

  always_comb begin
    advance   = ex_valid & ~stall;
    is_pm     = (ex_class == CLS_PMASK);
    is_arith  = (ex_class == CLS_ARITH);
    // A mask instruction loads only when its own bit lets it run.
    do_load   = advance & is_pm & state_q[0];
    do_cancel = advance & ~do_load & ~is_arith;
  end

  pmask_select #(.MASK_W(MASK_W)) u_sel (
    .reg_is_zero (reg_is_zero),
    .mask_nz     (imm_mask_nz),
    .mask_z      (imm_mask_z),
    .chosen      (sel_mask)
  );

  pmask_shiftreg #(.MASK_W(MASK_W)) u_sr (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .advance  (advance),
    .load     (do_load),
    .cancel   (do_cancel),
    .load_val (sel_mask),
    .mask_q   (state_q)
  );

  pmask_gate u_gate (
    .ex_valid      (ex_valid),
    .mask_lsb      (state_q[0]),
    .ex_nullify    (ex_nullify),
    .ex_keep_valid (ex_keep_valid)
  );
endmodule

// File: rtl/pmask_checker.sv
module pmask_checker #(
  parameter int MASK_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ex_valid,
  input logic [1:0]        ex_class,
  input logic [MASK_W-1:0] imm_mask_nz,
  input logic [MASK_W-1:0] imm_mask_z,
  input logic              reg_is_zero,
  input logic              stall,
  input logic              flush,
  input logic [MASK_W-1:0] mask_q,
  input logic              ex_nullify,
  input logic              ex_keep_valid
);
  localparam logic [MASK_W-1:0] ONES = '1;
  logic adv;
  assign adv = ex_valid && !stall && !flush;

  AST_RESET_ONES: assert property (@(posedge clk) rst |=> (mask_q == ONES)); // R1
  AST_PM_LOAD: assert property (@(posedge clk) disable iff (rst)
    (adv && ex_class == 2'd1 && mask_q[0]) |=>
      (mask_q == ($past(reg_is_zero) ? $past(imm_mask_z) : $past(imm_mask_nz)))); // R2
  AST_OUT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ex_nullify && ex_keep_valid) && ((ex_nullify || ex_keep_valid) == ex_valid)); // R3
  AST_SHIFT_FILL: assert property (@(posedge clk) disable iff (rst)
    (adv && ex_class == 2'd0) |=> (mask_q == {1'b1, $past(mask_q[MASK_W-1:1])})); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stall && !flush) |=> $stable(mask_q)); // R5
  AST_BUBBLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ex_valid && !flush) |=> $stable(mask_q)); // R6
  AST_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (adv && ex_class != 2'd0 && !(ex_class == 2'd1 && mask_q[0])) |=> (mask_q == ONES)); // R7
  AST_FLUSH_ONES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (mask_q == ONES)); // R10
endmodule

bind pmask_nullifier pmask_checker #(.MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_class(ex_class),
  .imm_mask_nz(imm_mask_nz), .imm_mask_z(imm_mask_z),
  .reg_is_zero(reg_is_zero), .stall(stall), .flush(flush),
  .mask_q(state_q), .ex_nullify(ex_nullify), .ex_keep_valid(ex_keep_valid)
);

// File: tb/sim_pmask_nullifier.sv
`timescale 1ns/1ps
module sim_pmask_nullifier;
  logic       clk = 1'b0;
  logic       rst, ex_valid, reg_is_zero, stall, flush;
  logic [1:0] ex_class;
  logic [7:0] imm_mask_nz, imm_mask_z;
  logic       ex_nullify, ex_keep_valid;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pmask_nullifier #(.MASK_W(8)) u0 (
    .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_class(ex_class),
    .imm_mask_nz(imm_mask_nz), .imm_mask_z(imm_mask_z),
    .reg_is_zero(reg_is_zero), .stall(stall), .flush(flush),
    .ex_nullify(ex_nullify), .ex_keep_valid(ex_keep_valid)
  );

  // {valid, class[1:0], mask_nz[7:0], mask_z[7:0], rz, stall, flush, exp_null, exp_keep}
  localparam int N = 28;
  localparam logic [23:0] TBL [N] = '{
    {1'b1,2'd1,8'hAA,8'h55,1'b0,1'b0,1'b0,1'b0,1'b1}, // R2 load 0xAA (rz=0)
    {1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0}, // R3 1st nulled
    {1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}, // R3 2nd kept
    {1'b1,2'd0,8'h00,8'h00,1'b0,1'b1,1'b0,1'b1,1'b0}, // R5 3rd stalled
    {1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0}, // R5 3rd advances, same bit
    {1'b0,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0}, // R6 bubble
    {1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}, // R6 4th kept
    {1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0}, // R3 5th nulled
    {1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}, // R3 6th kept
    {1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0}, // R3 7th nulled
    {1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}, // R4 8th kept, ones filled
    {1'b1,2'd1,8'h00,8'h0F,1'b1,1'b0,1'b0,1'b0,1'b1}, // R2 load 0x0F (rz=1)
    {1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}, // R4 bit0 kept
    {1'b1,2'd2,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}, // R7 non-arith kept, cancels
    {1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}, // R7 0x0F would keep too
    {1'b1,2'd1,8'hFE,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}, // R2 load 0xFE
    {1'b1,2'd1,8'h00,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0}, // R9 mask instr nulled
    {1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}, // R9 did not load 0x00
    {1'b1,2'd1,8'h02,8'hFF,1'b0,1'b0,1'b0,1'b0,1'b1}, // R2 load 0x02
    {1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0}, // R3 bit0 of 0x02
    {1'b1,2'd1,8'hFF,8'h00,1'b1,1'b0,1'b0,1'b0,1'b1}, // R8 overwrite with 0x00
    {1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0}, // R8 new mask applies
    {1'b1,2'd0,8'h00,8'h00,1'b0,1'b1,1'b1,1'b1,1'b0}, // R10 flush over stall
    {1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}, // R10 mask cleared
    {1'b1,2'd1,8'h00,8'hFF,1'b1,1'b0,1'b0,1'b0,1'b1}, // R2 load 0xFF
    {1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}, // R4 no nulls
    {1'b1,2'd3,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}, // R7 class 3
    {1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}  // R4
  };

  task automatic check(input string tag, input logic en, input logic ek);
    checks++;
    if (ex_nullify !== en || ex_keep_valid !== ek) begin
      failures++;
      $display("FAIL %s: null/keep actual=%b%b expected=%b%b", tag,
               ex_nullify, ex_keep_valid, en, ek);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] c, input logic [7:0] nz,
                       input logic [7:0] z, input logic rz, input logic st, input logic fl);
    ex_valid = v; ex_class = c; imm_mask_nz = nz; imm_mask_z = z;
    reg_is_zero = rz; stall = st; flush = fl;
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b0, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    drive(1'b1, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    #1 check("R1 after reset", 1'b0, 1'b1);
    @(posedge clk);

    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      drive(TBL[i][23], TBL[i][22:21], TBL[i][20:13], TBL[i][12:5],
            TBL[i][4], TBL[i][3], TBL[i][2]);
      #1 check($sformatf("R3 table row %0d", i), TBL[i][1], TBL[i][0]);
      @(posedge clk);
    end

    // R4: an all-zero mask nulls exactly eight instructions
    @(negedge clk) drive(1'b1, 2'd1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    @(posedge clk);
    for (int k = 0; k < 9; k++) begin
      @(negedge clk) drive(1'b1, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      #1 check($sformatf("R4 window instr %0d", k + 1), k < 8, k >= 8);
      @(posedge clk);
    end

    // R1: reset in the middle of an active mask
    @(negedge clk) drive(1'b1, 2'd1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk) drive(1'b1, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    #1 check("R3 before mid reset", 1'b1, 1'b0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1 check("R1 mid reset clears", 1'b0, 1'b1);
    @(posedge clk);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule